// File: doc/BRIEF.md
# Inter-core interrupt signalling unit

This unit lets any core in a small cluster raise an interrupt toward any other core. It is driven by a single command port. On each cycle at most one command is presented with a valid strobe, and that command carries an opcode, the number of the core issuing it and one core-number parameter. Inside, the unit keeps one pending flag for every ordered pair of sender and target. A target's interrupt line is the OR of the flags pointing at it. When several senders raise toward the same target, their requests merge into that one line.

A target core services its line in three steps. It issues a source query and gets back a one-hot-per-sender mask in the readback register. It then clears each sender that it finds in the mask with a separate acknowledge command, naming that sender by index. A sending core can also ask whether a given target already has anything pending, and can skip a redundant raise when it does. The results of read-type commands are held in one readback register until the next read-type command replaces them.

Top module: `ici_unit`

## Requirements
- R1: While reset is active, every pending flag is clear, every interrupt output is low and readback is zero.
- R2: Opcode 2'b00 (raise), with a parameter that differs from the issuing core, sets the flag from issuer to parameter. The interrupt output of that target is high from the cycle after the command, and no other interrupt output changes.
- R3: A raise whose parameter equals the issuing core changes nothing.
- R4: A raise to a sender-target pair that is already pending has no further effect, so a single acknowledge clears the pair.
- R5: Each interrupt output is high exactly when at least one flag toward that core is set. Several senders toward one target share that one output.
- R6: Opcode 2'b01 (status query) loads readback, in the cycle after the command, with 1 when the target named by the parameter has any flag set and with 0 otherwise.
- R7: Opcode 2'b10 (source query) loads readback with a mask in which bit i is set exactly when core i has a flag set toward the issuing core (core 0 gives 1, core 1 gives 2, core 2 gives 4, core 3 gives 8). All higher bits are zero.
- R8: Opcode 2'b11 (acknowledge) clears only the flag from the sender named by the parameter toward the issuing core. The issuer's interrupt output falls in the cycle after its last flag is cleared, and the other outputs do not change.
- R9: Readback changes only on status or source queries. Raise and acknowledge commands, and cycles with the valid strobe low, leave it unchanged.
- R10: While the valid strobe is low, no flag and no output changes, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Opcode: 00 raise, 01 status query, 10 source query, 11 acknowledge |
| cmd_core | input | ID_W (2) | Number of the issuing core |
| cmd_param | input | ID_W (2) | Target core (raise, status) or sender core (acknowledge) |
| irq | output | N_CORES (4) | One interrupt line per target core |
| readback | output | RB_W (32) | Result of the most recent read-type command |

## Verification
The assertions check on every cycle that the interrupt outputs move only where the current command points: a raise affects only its target, an acknowledge affects only its issuer, and idle cycles and self-raises change nothing. They also check that both query results agree with the interrupt lines of the cycle before, and that readback holds between queries. The exact contents of the matrix only show up under the bench's scenarios. These are merged senders, duplicate raises, partial acknowledges and long mixed command streams, which the bench compares against its own pair-by-pair model on every cycle.

// File: rtl/ici_pkg.sv
package ici_pkg;
  typedef enum logic [1:0] {
    OP_RAISE  = 2'b00,
    OP_STATUS = 2'b01,
    OP_SOURCE = 2'b10,
    OP_ACK    = 2'b11
  } ici_op_e;
endpackage

// File: rtl/ici_cmd_decode.sv
module ici_cmd_decode
  import ici_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ID_W    = 2
) (
  input  logic                            cmd_valid,
  input  logic [1:0]                      cmd_op,
  input  logic [ID_W-1:0]                 cmd_core,
  input  logic [ID_W-1:0]                 cmd_param,
  output logic [N_CORES-1:0][N_CORES-1:0] set_mat,
  output logic [N_CORES-1:0][N_CORES-1:0] clr_mat,
  output logic                            rd_status,
  output logic                            rd_source
);
  ici_op_e op;
  logic    core_ok;
  logic    param_ok;
  logic    is_raise;
  logic    is_ack;

  always_comb begin
    op        = ici_op_e'(cmd_op);
    core_ok   = (32'(cmd_core)  < N_CORES);
    param_ok  = (32'(cmd_param) < N_CORES);
    is_raise  = cmd_valid && (op == OP_RAISE) && core_ok && param_ok
                && (cmd_param != cmd_core);
    is_ack    = cmd_valid && (op == OP_ACK) && core_ok && param_ok;
    rd_status = cmd_valid && (op == OP_STATUS);
    rd_source = cmd_valid && (op == OP_SOURCE);
  end

  // set_mat / clr_mat are indexed [target][sender]
  for (genvar t = 0; t < N_CORES; t++) begin : g_tgt
    for (genvar s = 0; s < N_CORES; s++) begin : g_snd
      always_comb begin
        set_mat[t][s] = is_raise && (32'(cmd_param) == t) && (32'(cmd_core) == s);
        clr_mat[t][s] = is_ack   && (32'(cmd_core)  == t) && (32'(cmd_param) == s);
      end
    end
  end
endmodule

// File: rtl/ici_pend_matrix.sv
module ici_pend_matrix #(
  parameter int N_CORES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_CORES-1:0][N_CORES-1:0] set_mat,
  input  logic [N_CORES-1:0][N_CORES-1:0] clr_mat,
  output logic [N_CORES-1:0][N_CORES-1:0] pend_q
);
  for (genvar t = 0; t < N_CORES; t++) begin : g_tgt
    for (genvar s = 0; s < N_CORES; s++) begin : g_snd
      logic cell_en;
      logic cell_d;

      always_comb begin
        cell_en = set_mat[t][s] | clr_mat[t][s];
        cell_d  = set_mat[t][s] & ~clr_mat[t][s];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[t][s] <= 1'b0;
        end else if (cell_en) begin
          pend_q[t][s] <= cell_d;
        end
      end
    end
  end
endmodule

// File: rtl/ici_readback.sv
module ici_readback #(
  parameter int N_CORES = 4,
  parameter int ID_W    = 2,
  parameter int RB_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_status,
  input  logic                            rd_source,
  input  logic [ID_W-1:0]                 cmd_core,
  input  logic [ID_W-1:0]                 cmd_param,
  input  logic [N_CORES-1:0][N_CORES-1:0] pend_q,
  output logic [RB_W-1:0]                 readback
);
  logic [RB_W-1:0] rb_d;
  logic            rb_en;

  always_comb begin
    rb_en = rd_status | rd_source;
    rb_d  = '0;
    if (rd_source) begin
      if (32'(cmd_core) < N_CORES) rb_d = RB_W'(pend_q[cmd_core]);
    end else if (rd_status) begin
      if (32'(cmd_param) < N_CORES) rb_d = RB_W'(|pend_q[cmd_param]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readback <= '0;
    end else if (rb_en) begin
      readback <= rb_d;
    end
  end
endmodule

// File: rtl/ici_unit.sv
module ici_unit #(
  parameter int N_CORES = 4,
  parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  parameter int RB_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [ID_W-1:0]      cmd_core,
  input  logic [ID_W-1:0]      cmd_param,
  output logic [N_CORES-1:0]   irq,
  output logic [RB_W-1:0]      readback
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]          rst_sync_q;
  logic                            rst_n_sync;
  logic [N_CORES-1:0][N_CORES-1:0] set_mat;
  logic [N_CORES-1:0][N_CORES-1:0] clr_mat;
  logic [N_CORES-1:0][N_CORES-1:0] pend_q;
  logic                            rd_status;
  logic                            rd_source;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  always_comb rst_n_sync = rst_sync_q[SYNC_STAGES-1];

  ici_cmd_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_core  (cmd_core),
    .cmd_param (cmd_param),
    .set_mat   (set_mat),
    .clr_mat   (clr_mat),
    .rd_status (rd_status),
    .rd_source (rd_source)
  );

  ici_pend_matrix #(.N_CORES(N_CORES)) u_mat (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_mat (set_mat),
    .clr_mat (clr_mat),
    .pend_q  (pend_q)
  );

  ici_readback #(.N_CORES(N_CORES), .ID_W(ID_W), .RB_W(RB_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .rd_status (rd_status),
    .rd_source (rd_source),
    .cmd_core  (cmd_core),
    .cmd_param (cmd_param),
    .pend_q    (pend_q),
    .readback  (readback)
  );

  for (genvar t = 0; t < N_CORES; t++) begin : g_irq
    always_comb irq[t] = |pend_q[t];
  end
endmodule

// File: rtl/ici_unit_chk.sv
module ici_unit_chk #(
  parameter int N_CORES = 4,
  parameter int ID_W    = 2,
  parameter int RB_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [ID_W-1:0]    cmd_core,
  input logic [ID_W-1:0]    cmd_param,
  input logic [N_CORES-1:0] irq,
  input logic [RB_W-1:0]    readback
);
  logic [N_CORES-1:0] core_bit;
  logic [N_CORES-1:0] param_bit;

  always_comb begin
    core_bit  = N_CORES'(1) << cmd_core;
    param_bit = N_CORES'(1) << cmd_param;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (irq == '0) && (readback == '0)); // R1

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b00 && cmd_param != cmd_core |=> irq[$past(cmd_param)]); // R2

  AST_RAISE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b00 |=> (irq & ~$past(param_bit)) == ($past(irq) & ~$past(param_bit))); // R2

  AST_SELF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b00 && cmd_param == cmd_core |=> $stable(irq)); // R3

  AST_STATUS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b01 |=> readback == RB_W'($past(irq[cmd_param]))); // R6

  AST_SOURCE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b10 |=> (readback != '0) == $past(irq[cmd_core])); // R7

  AST_ACK_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b11 |=> (irq & ~$past(core_bit)) == ($past(irq) & ~$past(core_bit))); // R8

  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> $stable(readback)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(irq)); // R10
endmodule

bind ici_unit ici_unit_chk #(.N_CORES(N_CORES), .ID_W(ID_W), .RB_W(RB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_core  (cmd_core),
  .cmd_param (cmd_param),
  .irq       (irq),
  .readback  (readback)
);

// File: tb/ici_unit_bench.sv
module ici_unit_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [1:0]  cmd_core = 2'b00;
  logic [1:0]  cmd_param = 2'b00;
  logic [3:0]  irq;
  logic [31:0] readback;

  int checks = 0;
  int errors = 0;

  // reference: pending flags by target, bit = sender
  bit [3:0] m_pend [N];
  int       m_rb;

  always #4 clk = ~clk;

  ici_unit u_ici_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_core(cmd_core), .cmd_param(cmd_param), .irq(irq), .readback(readback)
  );

  function automatic bit [3:0] exp_irq();
    bit [3:0] v;
    for (int t = 0; t < N; t++) v[t] = (m_pend[t] != 0);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int op, int core, int param, string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = 2'(op); cmd_core = 2'(core); cmd_param = 2'(param);
    @(posedge clk);
    if (v) begin
      case (op)
        0: if (param != core) m_pend[param][core] = 1'b1;
        1: m_rb = (m_pend[param] != 0) ? 1 : 0;
        2: m_rb = int'(m_pend[core]);
        default: m_pend[core][param] = 1'b0;
      endcase
    end
    #2;
    check(tag, 32'(irq), 32'(exp_irq()), "irq");
    check(tag, readback, 32'(m_rb), "readback");
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < N; t++) m_pend[t] = '0;
    m_rb = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'(irq), 32'h0, "irq in reset");
    check("R1", readback, 32'h0, "readback in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1", 32'(irq), 32'h0, "irq after reset");

    step(1, 0, 0, 2, "R2");          // core0 -> core2
    step(1, 0, 1, 1, "R3");          // self raise ignored
    step(1, 0, 3, 2, "R5");          // core3 -> core2 merges
    step(1, 0, 0, 2, "R4");          // duplicate
    step(1, 2, 2, 0, "R7");          // mask should be 9
    check("R7", readback, 32'h9, "source mask");
    step(1, 1, 1, 2, "R6");          // status of core2 -> 1
    step(1, 1, 0, 1, "R6");          // status of core1 -> 0
    step(1, 3, 2, 0, "R8");          // partial ack, irq2 stays
    check("R8", 32'(irq[2]), 32'h1, "irq2 after partial ack");
    step(1, 0, 2, 1, "R9");          // raise leaves readback
    step(0, 3, 2, 3, "R10");         // idle with ack payload
    check("R10", 32'(irq[2]), 32'h1, "irq2 while idle");
    step(1, 3, 2, 3, "R8");          // last flag cleared
    check("R8", 32'(irq[2]), 32'h0, "irq2 after last ack");
    step(1, 3, 2, 3, "R4");          // re-ack harmless
    step(1, 2, 1, 0, "R7");          // core1 mask = 4
    step(1, 3, 1, 2, "R8");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      step(($urandom_range(0, 7) != 0), op, $urandom_range(0, 3),
           $urandom_range(0, 3), (op == 0) ? "R2" : (op == 1) ? "R6" : (op == 2) ? "R7" : "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule